// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits between a set of ten interrupt request lines and a CPU core. Each line is already the OR of its sources. The block selects one line and drives an interrupt request together with that line's vector address. The CPU answers with an acknowledge pulse when it accepts the interrupt, and with a return strobe when its handler finishes.

Every line is configured as either low priority or elevated priority. An elevated line resolves to the highest level on the first two lines and to the high level on the remaining eight, so no other level can be chosen. The block keeps one in-service bit per level. A pending request reaches the CPU only when its level is strictly above the top level already being serviced, which allows handlers to nest up to three deep.

Each line is either edge-type or level-type. An edge-type line remembers a request pulse until that line is acknowledged. A level-type line simply follows its input. A disabled line takes no part in arbitration, but any request it has latched is kept.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset the in-service state and all latched requests are clear, so `irq_o` is 0 and `vec_o` is 0 while no level-type request is active. A request pulse that arrives during reset is not latched.
- R2: The vector address of line i is 0x03 + 8*i, giving 0x03 to 0x4B. `vec_o` shows the winning line's address while `irq_o` is 1 and 0 otherwise.
- R3: When `lvl_i[i]` is 0, line i is low. When it is 1, line i is highest if i is 0 or 1, and high if i is 2 to 9. The ordering is highest > high > low.
- R4: Among the eligible requests, the one with the highest level wins.
- R5: Among eligible requests of the same level, the lowest line index (the lowest vector address) wins.
- R6: A request is eligible only if its level is strictly greater than the top level in service. Requests of equal or lower level are held off, and `irq_o` is 0 whenever only such requests exist.
- R7: `ack_i` while `irq_o` is 1 sets the in-service bit of the winner's level on the next clock. `ack_i` while `irq_o` is 0 changes nothing.
- R8: `reti_i` clears only the highest in-service bit that is set. Lower bits remain set.
- R9: When `edge_i[i]` is 1, a one-cycle pulse on `req_i[i]` stays pending until line i is acknowledged, and that acknowledge clears it. When `edge_i[i]` is 0, the line's request equals `req_i[i]` and an acknowledge does not clear it.
- R10: A line with `en_i[i]` at 0 never wins. A latched edge-type request on that line survives and competes again once the line is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 10 | Request line per vector |
| edge_i | input | 10 | 1 = edge-type line (latched), 0 = level-type line |
| en_i | input | 10 | Per-line enable |
| lvl_i | input | 10 | Per-line level select, 0 = low, 1 = elevated |
| ack_i | input | 1 | CPU acknowledge of the presented interrupt |
| reti_i | input | 1 | CPU return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector address of the winning line |

## Verification
Some properties are checked on every cycle:
- An accepted acknowledge sets exactly the winner's level bit.
- A return strobe removes exactly one in-service bit.
- In-service state holds steady when neither strobe is present.
- A granted line is always enabled and always above the in-service threshold.
- No request is offered while the highest level is in service.
- The vector lands on the 0x03 + 8*i grid.
- A granted edge-type line drops its pending flag.

Other behaviour only the bench's scenarios can show:
- The exact priority and tie-break choices across mixed patterns.
- The level mapping of the first two lines against the rest.
- Three-deep nesting unwinding in the correct order.
- A pulse during reset being ignored.
- Level-type lines surviving an acknowledge.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
  localparam int   N_LVL    = 3;
endpackage

// File: rtl/irq_lvl_map.sv
`timescale 1ns/1ps
// Maps the one-bit level select onto the level each line is allowed to use.
module irq_lvl_map
  import irq_nest_pkg::*;
#(
  parameter int N_VEC = 10,
  parameter int N_TOP = 2
) (
  input  logic [N_VEC-1:0]       sel_i,
  output lvl_t [N_VEC-1:0]       lvl_o
);
  for (genvar g = 0; g < N_VEC; g++) begin : g_map
    if (g < N_TOP) begin : g_top
      assign lvl_o[g] = sel_i[g] ? LVL_TOP : LVL_LOW;
    end else begin : g_high
      assign lvl_o[g] = sel_i[g] ? LVL_HIGH : LVL_LOW;
    end
  end
endmodule

// File: rtl/irq_pend.sv
`timescale 1ns/1ps
module irq_pend #(
  parameter int N_VEC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_VEC-1:0] req_i,
  input  logic [N_VEC-1:0] edge_i,
  input  logic [N_VEC-1:0] clr_i,
  output logic [N_VEC-1:0] pend_q_o,
  output logic [N_VEC-1:0] pend_o
);
  logic [N_VEC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~(clr_i & edge_i)) | (req_i & edge_i);
  end

  assign pend_q_o = pend_q;
  assign pend_o   = (edge_i & pend_q) | (~edge_i & req_i);
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
// Highest level first; within a level, lowest index.
module irq_pick
  import irq_nest_pkg::*;
#(
  parameter int N_VEC = 10,
  localparam int IDX_W = $clog2(N_VEC)
) (
  input  logic [N_VEC-1:0] cand_i,
  input  lvl_t [N_VEC-1:0] lvl_i,
  input  lvl_t             thr_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  always_comb begin
    lvl_o = LVL_NONE;
    idx_o = '0;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (cand_i[i] && (lvl_i[i] > thr_i) && (lvl_i[i] >= lvl_o)) begin
        lvl_o = lvl_i[i];
        idx_o = IDX_W'(i);
      end
    end
    vld_o = (lvl_o != LVL_NONE);
  end
endmodule

// File: rtl/irq_svc.sv
`timescale 1ns/1ps
// In-service bits: bit k stands for level k+1.
module irq_svc
  import irq_nest_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  lvl_t             set_lvl_i,
  input  logic             reti_i,
  output logic [N_LVL-1:0] ins_o,
  output lvl_t             thr_o
);
  logic [N_LVL-1:0] ins_q, ins_d, drop;

  always_comb begin
    drop = '0;
    for (int k = 0; k < N_LVL; k++) begin
      if (ins_q[k]) drop = '0;
      if (ins_q[k]) drop[k] = 1'b1;
    end
    ins_d = reti_i ? (ins_q & ~drop) : ins_q;
    if (set_i && set_lvl_i != LVL_NONE) ins_d[set_lvl_i - 2'd1] = 1'b1;
  end

  always_comb begin
    thr_o = LVL_NONE;
    for (int k = 0; k < N_LVL; k++)
      if (ins_q[k]) thr_o = lvl_t'(k + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ins_q <= '0;
    else         ins_q <= ins_d;
  end

  assign ins_o = ins_q;
endmodule

// File: rtl/irq_nest_arb.sv
`timescale 1ns/1ps
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int N_VEC    = 10,
  parameter int N_TOP    = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDX_W   = $clog2(N_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_VEC-1:0] req_i,
  input  logic [N_VEC-1:0] edge_i,
  input  logic [N_VEC-1:0] en_i,
  input  logic [N_VEC-1:0] lvl_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  lvl_t [N_VEC-1:0] line_lvl;
  logic [N_VEC-1:0] pend, pend_q, clr;
  logic [N_LVL-1:0] ins;
  lvl_t             thr, win_lvl;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic             grant;

  irq_lvl_map #(.N_VEC(N_VEC), .N_TOP(N_TOP)) u_map (
    .sel_i (lvl_i),
    .lvl_o (line_lvl)
  );

  irq_pend #(.N_VEC(N_VEC)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .edge_i   (edge_i),
    .clr_i    (clr),
    .pend_q_o (pend_q),
    .pend_o   (pend)
  );

  irq_pick #(.N_VEC(N_VEC)) u_pick (
    .cand_i (pend & en_i),
    .lvl_i  (line_lvl),
    .thr_i  (thr),
    .vld_o  (win_vld),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  assign grant = ack_i & win_vld;
  assign clr   = grant ? (N_VEC'(1) << win_idx) : '0;

  irq_svc u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (grant),
    .set_lvl_i (win_lvl),
    .reti_i    (reti_i),
    .ins_o     (ins),
    .thr_o     (thr)
  );

  assign irq_o = win_vld;
  assign vec_o = win_vld ? VEC_W'(VEC_BASE + VEC_STEP * int'(win_idx)) : '0;
endmodule

// File: rtl/irq_nest_arb_chk.sv
`timescale 1ns/1ps
module irq_nest_arb_chk
  import irq_nest_pkg::*;
#(
  parameter int N_VEC    = 10,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDX_W   = $clog2(N_VEC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_VEC-1:0] req_i,
  input logic [N_VEC-1:0] edge_i,
  input logic [N_VEC-1:0] en_i,
  input logic             ack_i,
  input logic             reti_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [N_LVL-1:0] ins,
  input lvl_t             thr,
  input lvl_t             win_lvl,
  input logic [IDX_W-1:0] win_idx,
  input logic [N_VEC-1:0] pend_q
);
  localparam int VEC_MAX = VEC_BASE + VEC_STEP * (N_VEC - 1);

  a_r2_vec_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((int'(vec_o) - VEC_BASE) % VEC_STEP == 0) && (int'(vec_o) <= VEC_MAX));

  a_r6_above_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_lvl > thr));

  a_r6_top_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins[N_LVL-1] |-> !irq_o);

  a_r7_ack_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !reti_i) |=> ins[$past(win_lvl) - 2'd1]);

  a_r7_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !reti_i) |=> $stable(ins));

  a_r8_reti_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && ins != '0) |=> ($countones(ins) == $countones($past(ins)) - 1));

  a_r9_edge_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && edge_i[win_idx] && !req_i[win_idx]) |=> !pend_q[$past(win_idx)]);

  a_r10_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_i[win_idx]);
endmodule

bind irq_nest_arb irq_nest_arb_chk #(
  .N_VEC(N_VEC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .edge_i  (edge_i),
  .en_i    (en_i),
  .ack_i   (ack_i),
  .reti_i  (reti_i),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .ins     (ins),
  .thr     (thr),
  .win_lvl (win_lvl),
  .win_idx (win_idx),
  .pend_q  (pend_q)
);

// File: tb/irq_nest_arb_tb.sv
`timescale 1ns/1ps
module irq_nest_arb_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] req = '0, edg = '0, en = '0, lvl = '0;
  logic       ack = 1'b0, reti = 1'b0;
  logic       irq;
  logic [7:0] vec;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  irq_nest_arb u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .edge_i(edg), .en_i(en),
    .lvl_i(lvl), .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_o(vec)
  );

  typedef struct packed {
    logic [9:0] req;
    logic [9:0] en;
    logic [9:0] lvl;
    logic       irq;
    logic [7:0] vec;
  } row_t;

  localparam row_t TBL [10] = '{
    '{10'h000, 10'h3FF, 10'h000, 1'b0, 8'h00},  // R2 idle
    '{10'h020, 10'h3FF, 10'h000, 1'b1, 8'h2B},  // R2 single line
    '{10'h088, 10'h3FF, 10'h000, 1'b1, 8'h1B},  // R5 tie
    '{10'h088, 10'h3FF, 10'h080, 1'b1, 8'h3B},  // R4 high beats low
    '{10'h006, 10'h3FF, 10'h006, 1'b1, 8'h0B},  // R3 line1 highest over high
    '{10'h201, 10'h3FF, 10'h200, 1'b1, 8'h4B},  // R4 line9 high
    '{10'h050, 10'h3EF, 10'h000, 1'b1, 8'h33},  // R10 line4 disabled
    '{10'h100, 10'h2FF, 10'h000, 1'b0, 8'h00},  // R10 only line disabled
    '{10'h3FF, 10'h3FF, 10'h3FF, 1'b1, 8'h03},  // R5 all highest/high
    '{10'h3FC, 10'h3FF, 10'h120, 1'b1, 8'h2B}   // R5 two high lines
  };

  task automatic check(string tag, logic a_irq, logic [7:0] a_vec,
                       logic e_irq, logic [7:0] e_vec);
    checks++;
    if (a_irq !== e_irq || a_vec !== e_vec) begin
      errors++;
      $display("FAIL %s: irq=%0b vec=%02h expected irq=%0b vec=%02h",
               tag, a_irq, a_vec, e_irq, e_vec);
    end
  endtask

  // inputs change just after a falling edge; outputs sampled 1 ns later
  task automatic settle_chk(string tag, logic e_irq, logic [7:0] e_vec);
    #1;
    check(tag, irq, vec, e_irq, e_vec);
    @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: edge pulse during reset must not be latched
    en = '1; edg = 10'h010;
    @(negedge clk); req = 10'h010; @(negedge clk); req = '0;
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    settle_chk("R1 reset state", 1'b0, 8'h00);
    edg = '0;

    foreach (TBL[i]) begin
      req = TBL[i].req; en = TBL[i].en; lvl = TBL[i].lvl;
      settle_chk($sformatf("R2/R3/R4/R5/R10 row %0d", i), TBL[i].irq, TBL[i].vec);
    end
    req = '0; en = '1; lvl = '0;
    @(negedge clk);

    // R7: ack with nothing pending is ignored
    do_ack();
    req = 10'h008;
    settle_chk("R7 stray ack ignored", 1'b1, 8'h1B);

    // nesting: low in service
    do_ack();
    settle_chk("R6 equal level held", 1'b0, 8'h00);
    req = 10'h00C;
    settle_chk("R6 lower index same level held", 1'b0, 8'h00);
    req = 10'h04C; lvl = 10'h040;
    settle_chk("R6 high preempts low", 1'b1, 8'h33);
    do_ack();
    settle_chk("R6 high in service blocks high", 1'b0, 8'h00);
    req = 10'h04D; lvl = 10'h041;
    settle_chk("R3 line0 highest preempts", 1'b1, 8'h03);
    do_ack();
    settle_chk("R6 top level blocks all", 1'b0, 8'h00);
    do_reti();
    settle_chk("R8 top cleared, high kept", 1'b1, 8'h03);
    req = 10'h04C; lvl = 10'h040;
    settle_chk("R8 high still in service", 1'b0, 8'h00);
    do_reti();
    settle_chk("R8 low still in service", 1'b1, 8'h33);
    do_reti();
    settle_chk("R8 empty after three returns", 1'b1, 8'h33);
    req = '0; lvl = '0;
    settle_chk("R1 idle again", 1'b0, 8'h00);

    // R9 edge-type latching
    edg = 10'h010; req = 10'h010; @(negedge clk); req = '0;
    settle_chk("R9 pulse latched", 1'b1, 8'h23);
    en = 10'h3EF;
    settle_chk("R10 disabled hides pending", 1'b0, 8'h00);
    en = '1;
    settle_chk("R10 pending kept", 1'b1, 8'h23);
    do_ack(); do_reti();
    settle_chk("R9 ack cleared edge pending", 1'b0, 8'h00);

    // R9 level-type survives ack
    edg = '0; req = 10'h020;
    do_ack(); do_reti();
    settle_chk("R9 level line not cleared", 1'b1, 8'h2B);
    req = '0;
    settle_chk("R9 level line follows input", 1'b0, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule